// File: doc/BRIEF.md
# Illegal Instruction Exception Sequencer

This block sits next to the decode stage of a small in-order pipelined processor. In every cycle it looks at three flags for the instruction in decode: the opcode is undefined, the instruction occupies the slot right after a delayed branch, and the instruction would write the program counter. From these flags it decides whether an illegal instruction exception is taken, and of which of two kinds. An ordinary illegal instruction is undefined code outside a delay slot. An illegal-slot instruction is undefined code, or a program-counter write, placed inside a delay slot.

Once an exception is accepted, the faulting instruction keeps its fetch and decode slots. Every later slot is replaced by a fixed nine-slot exception sequence: fetch, decode, two execute slots, three memory-access slots, then two more execute slots. While this sequence runs the block stalls issue and flushes the fetch and decode registers, so that any instructions fetched past the fault are thrown away. It holds the selected vector number steady and raises numbered strobes during the memory-access slots, for a unit that saves state and reads the vector table. In the final execute slot it asks the fetch unit to redirect to the handler. The sequence is not a delayed branch, so nothing after it runs as a delay slot.

Top module: `illx_seq_top`

## Requirements
- R1: Valid decode with undefined code and the delay-slot flag low starts an ordinary exception: vector output equals VEC_ORD (default 4) and `exc_is_slot` is 0 for the whole sequence.
- R2: Valid decode with the delay-slot flag high and either undefined code or a program-counter write starts an illegal-slot exception: vector equals VEC_SLOT (default 6) and `exc_is_slot` is 1 for the whole sequence.
- R3: No sequence starts when `id_valid` is low, or when the instruction is defined and not a program-counter write in a delay slot (a program-counter write outside a delay slot is legal).
- R4: `seq_pos` reports the current slot number, counting fetch as 1, for the replaced slots 3 to 9 in the seven cycles after the accepting edge, and 0 when idle.
- R5: `busy` is high for exactly those seven cycles and drops in the cycle after the final execute slot.
- R6: `flush` is high in every busy cycle and low otherwise, discarding overrun fetches.
- R7: `ma_stb` is high only in slots 5, 6 and 7, with `ma_idx` equal to 0, 1 and 2 in that order; `ma_idx` is 0 when the strobe is low.
- R8: `redirect` is high for exactly one cycle, in slot 9 (the final execute slot).
- R9: `vector` and `exc_is_slot` are constant while busy and are 0 when idle.
- R10: Decode flags are ignored while busy: no restart, no change of kind or vector.
- R11: A new exception is accepted from flags presented in the first idle cycle after a sequence, taking its kind only from those flags.
- R12: Synchronous reset returns to idle with no busy, flush, strobe or redirect, ignores decode flags in the reset cycle, and aborts a running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode holds a real instruction |
| id_undef | input | 1 | Decoded opcode is undefined |
| id_in_dslot | input | 1 | Instruction sits in a delay slot |
| id_writes_pc | input | 1 | Instruction would write the program counter |
| busy | output | 1 | Sequence running; stalls issue from decode |
| flush | output | 1 | Squash fetch and decode registers |
| seq_pos | output | 4 | Current slot number of the sequence, 0 when idle |
| ma_stb | output | 1 | Memory-access slot strobe |
| ma_idx | output | 2 | Index of the memory-access slot |
| redirect | output | 1 | Start handler fetch |
| vector | output | 8 | Selected vector number |
| exc_is_slot | output | 1 | 1 for illegal-slot, 0 for ordinary |

## Verification
The bench goes after the classification corners: a program-counter write outside a delay slot, which a careless decoder would flag as illegal, and the same write inside one, which it must flag with the slot vector. It presents conflicting flags during a running sequence and ready flags in the very cycle busy drops; a design that re-armed early would restart or swap the vector, and one that re-armed late would lose the second fault. It checks that redirect falls exactly on slot 9, so an off-by-one in the tail count shows up as a redirect one slot early or late. It also asserts reset during a sequence and with flags present, which a design with asynchronous-style priority errors would let start anyway.

// File: rtl/illx_pkg.sv
package illx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HEAD = 2'd1,
        PH_MA   = 2'd2,
        PH_TAIL = 2'd3
    } illx_phase_e;

    typedef enum logic {
        EXC_ORD  = 1'b0,
        EXC_SLOT = 1'b1
    } illx_kind_e;

    typedef struct packed {
        logic       valid;
        logic       undef;
        logic       in_dslot;
        logic       writes_pc;
    } illx_flags_t;

    typedef struct packed {
        logic       take;
        illx_kind_e kind;
    } illx_req_t;

    // Slots already spent by the faulting instruction (fetch and decode).
    localparam int unsigned PRE_SLOTS = 2;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    function automatic illx_req_t classify(input illx_flags_t f);
        illx_req_t r;
        r.take = 1'b0;
        r.kind = EXC_ORD;
        if (f.valid) begin
            if (f.in_dslot && (f.undef || f.writes_pc)) begin
                r.take = 1'b1;
                r.kind = EXC_SLOT;
            end else if (f.undef) begin
                r.take = 1'b1;
                r.kind = EXC_ORD;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/illx_classify.sv
module illx_classify
    import illx_pkg::*;
(
    input  illx_flags_t flags,
    output illx_req_t   req
);
    always_comb begin
        req = classify(flags);
    end
endmodule

// File: rtl/illx_sequencer.sv
module illx_sequencer
    import illx_pkg::*;
#(
    parameter int unsigned HEAD_EX = 2,
    parameter int unsigned N_MA    = 3,
    parameter int unsigned TAIL_EX = 2,
    localparam int unsigned CNT_W  = $clog2(max3(HEAD_EX, N_MA, TAIL_EX) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  illx_req_t        req,
    output illx_phase_e      phase,
    output logic [CNT_W-1:0] cnt,
    output illx_kind_e       kind
);
    localparam logic [CNT_W-1:0] HEAD_LAST = CNT_W'(HEAD_EX - 1);
    localparam logic [CNT_W-1:0] MA_LAST   = CNT_W'(N_MA - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_EX - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            kind  <= EXC_ORD;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (req.take) begin
                        phase <= PH_HEAD;
                        cnt   <= '0;
                        kind  <= req.kind;
                    end
                end
                PH_HEAD: begin
                    if (cnt == HEAD_LAST) begin
                        phase <= PH_MA;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_MA: begin
                    if (cnt == MA_LAST) begin
                        phase <= PH_TAIL;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (cnt == TAIL_LAST) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    AST_MA_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MA) |-> (cnt <= MA_LAST)); // R7
    AST_KIND_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(kind)); // R10

endmodule

// File: rtl/illx_out_map.sv
module illx_out_map
    import illx_pkg::*;
#(
    parameter int unsigned HEAD_EX  = 2,
    parameter int unsigned N_MA     = 3,
    parameter int unsigned TAIL_EX  = 2,
    parameter int unsigned VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_ORD  = 8'd4,
    parameter logic [VEC_W-1:0] VEC_SLOT = 8'd6,
    parameter int unsigned CNT_W    = 2,
    parameter int unsigned POS_W    = 4,
    parameter int unsigned IDX_W    = 2
) (
    input  illx_phase_e      phase,
    input  logic [CNT_W-1:0] cnt,
    input  illx_kind_e       kind,
    output logic             busy,
    output logic             flush,
    output logic [POS_W-1:0] seq_pos,
    output logic             ma_stb,
    output logic [IDX_W-1:0] ma_idx,
    output logic             redirect,
    output logic [VEC_W-1:0] vector,
    output logic             exc_is_slot
);
    localparam logic [POS_W-1:0] BASE_HEAD = POS_W'(PRE_SLOTS + 1);
    localparam logic [POS_W-1:0] BASE_MA   = POS_W'(PRE_SLOTS + 1 + HEAD_EX);
    localparam logic [POS_W-1:0] BASE_TAIL = POS_W'(PRE_SLOTS + 1 + HEAD_EX + N_MA);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_EX - 1);

    logic [POS_W-1:0] base;

    always_comb begin
        unique case (phase)
            PH_HEAD: base = BASE_HEAD;
            PH_MA:   base = BASE_MA;
            PH_TAIL: base = BASE_TAIL;
            default: base = '0;
        endcase
    end

    always_comb begin
        busy        = (phase != PH_IDLE);
        flush       = busy;
        seq_pos     = busy ? (base + POS_W'(cnt)) : '0;
        ma_stb      = (phase == PH_MA);
        ma_idx      = ma_stb ? IDX_W'(cnt) : '0;
        redirect    = (phase == PH_TAIL) && (cnt == TAIL_LAST);
        exc_is_slot = busy && (kind == EXC_SLOT);
        if (!busy)
            vector = '0;
        else if (kind == EXC_SLOT)
            vector = VEC_SLOT;
        else
            vector = VEC_ORD;
    end

endmodule

// File: rtl/illx_seq_top.sv
module illx_seq_top
    import illx_pkg::*;
#(
    parameter int unsigned HEAD_EX  = 2,
    parameter int unsigned N_MA     = 3,
    parameter int unsigned TAIL_EX  = 2,
    parameter int unsigned VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_ORD  = 8'd4,
    parameter logic [VEC_W-1:0] VEC_SLOT = 8'd6,
    localparam int unsigned TOTAL   = PRE_SLOTS + HEAD_EX + N_MA + TAIL_EX,
    localparam int unsigned CNT_W   = $clog2(max3(HEAD_EX, N_MA, TAIL_EX) + 1),
    localparam int unsigned POS_W   = $clog2(TOTAL + 1),
    localparam int unsigned IDX_W   = (N_MA > 1) ? $clog2(N_MA) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid,
    input  logic             id_undef,
    input  logic             id_in_dslot,
    input  logic             id_writes_pc,
    output logic             busy,
    output logic             flush,
    output logic [POS_W-1:0] seq_pos,
    output logic             ma_stb,
    output logic [IDX_W-1:0] ma_idx,
    output logic             redirect,
    output logic [VEC_W-1:0] vector,
    output logic             exc_is_slot
);
    illx_flags_t      flags;
    illx_req_t        req;
    illx_phase_e      phase;
    logic [CNT_W-1:0] cnt;
    illx_kind_e       kind;

    assign flags = '{valid: id_valid, undef: id_undef,
                     in_dslot: id_in_dslot, writes_pc: id_writes_pc};

    illx_classify u_cls (
        .flags (flags),
        .req   (req)
    );

    illx_sequencer #(
        .HEAD_EX (HEAD_EX),
        .N_MA    (N_MA),
        .TAIL_EX (TAIL_EX)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .phase (phase),
        .cnt   (cnt),
        .kind  (kind)
    );

    illx_out_map #(
        .HEAD_EX  (HEAD_EX),
        .N_MA     (N_MA),
        .TAIL_EX  (TAIL_EX),
        .VEC_W    (VEC_W),
        .VEC_ORD  (VEC_ORD),
        .VEC_SLOT (VEC_SLOT),
        .CNT_W    (CNT_W),
        .POS_W    (POS_W),
        .IDX_W    (IDX_W)
    ) u_map (
        .phase       (phase),
        .cnt         (cnt),
        .kind        (kind),
        .busy        (busy),
        .flush       (flush),
        .seq_pos     (seq_pos),
        .ma_stb      (ma_stb),
        .ma_idx      (ma_idx),
        .redirect    (redirect),
        .vector      (vector),
        .exc_is_slot (exc_is_slot)
    );

    AST_REDIRECT_FINAL: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (busy && seq_pos == POS_W'(TOTAL))); // R8
    AST_REDIRECT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !busy); // R5
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ma_stb, redirect})); // R7
    AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(vector) && $stable(exc_is_slot))); // R9
    AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (seq_pos == $past(seq_pos) + 1'b1)); // R4
    AST_POS_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (seq_pos == POS_W'(PRE_SLOTS + 1))); // R4

endmodule

// File: tb/tb_illx_seq_top.sv
module tb_illx_seq_top;
    localparam int CLK_PER = 10;
    localparam int LAST_K  = 7;

    logic clk = 1'b0;
    logic rst, id_valid, id_undef, id_in_dslot, id_writes_pc;
    logic busy, flush, ma_stb, redirect, exc_is_slot;
    logic [3:0] seq_pos;
    logic [1:0] ma_idx;
    logic [7:0] vector;

    int n_checks = 0;
    int n_err    = 0;
    int mk       = 0;   // model: cycles into sequence, 0 = idle
    int mslot    = 0;   // model: kind latched
    bit finished = 0;

    always #(CLK_PER/2) clk = ~clk;

    illx_seq_top dut (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_undef(id_undef),
        .id_in_dslot(id_in_dslot), .id_writes_pc(id_writes_pc),
        .busy(busy), .flush(flush), .seq_pos(seq_pos), .ma_stb(ma_stb),
        .ma_idx(ma_idx), .redirect(redirect), .vector(vector),
        .exc_is_slot(exc_is_slot)
    );

    function automatic bit f_take(bit v, bit u, bit d, bit w);
        return v && (u || (d && w));
    endfunction
    function automatic int f_pos(int k);  return (k == 0) ? 0 : k + 2; endfunction
    function automatic bit f_ma(int k);   return (k >= 3) && (k <= 5); endfunction
    function automatic int f_idx(int k);  return f_ma(k) ? k - 3 : 0; endfunction
    function automatic int f_vec(int k, int s);
        return (k == 0) ? 0 : (s != 0 ? 6 : 4);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: drive inputs, step one clock, check at the next falling edge.
    task automatic cyc(bit r, bit v, bit u, bit d, bit w, string ctx);
        string vtag;
        rst = r; id_valid = v; id_undef = u; id_in_dslot = d; id_writes_pc = w;
        if (r) begin
            mk = 0; mslot = 0;
        end else if (mk == 0) begin
            if (f_take(v, u, d, w)) begin mk = 1; mslot = d ? 1 : 0; end
        end else begin
            mk = (mk == LAST_K) ? 0 : mk + 1;
        end
        @(posedge clk);
        @(negedge clk);
        vtag = (mk == 0) ? "R9" : (mslot != 0 ? "R2" : "R1");
        check({ctx, "/R5"}, "busy", int'(busy), int'(mk != 0));
        check({ctx, "/R6"}, "flush", int'(flush), int'(mk != 0));
        check({ctx, "/R4"}, "seq_pos", int'(seq_pos), f_pos(mk));
        check({ctx, "/R7"}, "ma_stb", int'(ma_stb), int'(f_ma(mk)));
        check({ctx, "/R7"}, "ma_idx", int'(ma_idx), f_idx(mk));
        check({ctx, "/R8"}, "redirect", int'(redirect), int'(mk == LAST_K));
        check({ctx, "/", vtag}, "vector", int'(vector), f_vec(mk, mslot));
        check({ctx, "/", vtag}, "exc_is_slot", int'(exc_is_slot), (mk != 0) ? mslot : 0);
    endtask

    task automatic idle_cycles(int n, string ctx);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, ctx);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_checks++; n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        rst = 1; id_valid = 0; id_undef = 0; id_in_dslot = 0; id_writes_pc = 0;
        @(negedge clk);
        // R12: reset with a faulting instruction present must not start
        cyc(1, 1, 1, 0, 0, "R12");
        cyc(1, 1, 1, 1, 1, "R12");
        // R1: ordinary illegal, whole sequence
        cyc(0, 1, 1, 0, 0, "R1");
        idle_cycles(8, "R1");
        // R2: undefined code in delay slot
        cyc(0, 1, 1, 1, 0, "R2");
        idle_cycles(8, "R2");
        // R2: pc write in delay slot
        cyc(0, 1, 0, 1, 1, "R2");
        idle_cycles(8, "R2");
        // R3: legal pc write outside delay slot, valid low, plain instruction
        cyc(0, 1, 0, 0, 1, "R3");
        cyc(0, 0, 1, 1, 1, "R3");
        cyc(0, 1, 0, 1, 0, "R3");
        idle_cycles(1, "R3");
        // R10: conflicting flags during sequence
        cyc(0, 1, 1, 0, 0, "R10");
        for (int i = 0; i < 6; i++) cyc(0, 1, 1, 1, 1, "R10");
        // R11: flags in the first idle cycle after the sequence are accepted
        cyc(0, 1, 1, 1, 0, "R11");
        cyc(0, 1, 1, 0, 0, "R11");
        for (int i = 0; i < 7; i++) cyc(0, 0, 0, 0, 0, "R11");
        idle_cycles(2, "R11");
        // R12: reset mid-sequence aborts
        cyc(0, 1, 1, 0, 0, "R12");
        idle_cycles(3, "R12");
        cyc(1, 0, 0, 0, 0, "R12");
        idle_cycles(2, "R12");
        // Constrained random
        void'($urandom(32'h1D5E_0A17));
        for (int i = 0; i < 3000; i++) begin
            bit r, v, u, d, w;
            r = ($urandom_range(0, 99) < 2);
            v = ($urandom_range(0, 99) < 70);
            u = ($urandom_range(0, 99) < 15);
            d = ($urandom_range(0, 99) < 25);
            w = ($urandom_range(0, 99) < 30);
            cyc(r, v, u, d, w, "RND");
        end
        summary();
    end
endmodule